// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port with a register bus. Each pin can be an output, driven from a data register, or an input. Every pin is sampled through a two-stage synchronizer. Software reads the synchronized pin levels from a read-only register.

Every pin can also raise an interrupt. The trigger type of each pin is a 2-bit field. The fields for the lower half of the pins are in one configuration register, and the fields for the upper half are in a second configuration register four bytes higher. A detected event sets a bit in a status register, and software clears that bit by writing 1 to it. A mask register selects which status bits reach the single combined interrupt line. The interrupt line is registered once.

The bus is a plain interface: valid, write, byte address and data. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the request and holds until the next read. Byte offsets:

- 0x00 data
- 0x04 direction
- 0x08 pad level
- 0x0C lower trigger configuration
- 0x10 upper trigger configuration
- 0x14 mask
- 0x18 status

Unmapped offsets read 0.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, mask and both configuration registers read 0, `pad_oe` is all zero and `irq_out` is low.
- R2: A direction bit of 1 makes its pin an output: `pad_oe` follows the direction register and `pad_out` follows the data register (offset 0x00). A direction bit of 0 leaves the pin as an input.
- R3: Offset 0x08 reads `pad_in` after two register stages. A read issued in the cycle right after a pin change still returns the old level. Writes to 0x08 have no effect.
- R4: The trigger field of pin i sits at bits 2*(i mod 16)+1:2*(i mod 16). For pins 0 to 15 it is in offset 0x0C; for pins 16 to 31 it is in offset 0x10. The encodings are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: A level-type pin sets its status bit in every cycle its synchronized input is at the active level. A clear while the input is still active leaves the bit reading 1.
- R6: An edge-type pin keeps its status bit set after the pin returns to idle, until software clears it.
- R7: Writing to the status register (0x18) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: A status bit is recorded whatever its mask bit is. `irq_out` is the OR of status AND mask, registered one cycle.
- R9: If a detected event and a software clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output levels from the data register |
| pad_oe | output | 32 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench lines up an edge event with a software clear on the same status bit in the same cycle. A design where the clear wins would lose that interrupt and read back 0. It clears a level-type pin while the input is still active; a design that treats levels like edges would read 0. It drives an edge-type pin back to idle before reading; a design that tracks the live level would drop the bit. It programs a pin in the upper half and checks that its field sits in the second configuration register at the folded bit position; a wrong split or shift would trigger the wrong pin or trigger on the wrong edge. It reads the pad register in the cycle after a change; a design with too few synchronizer stages would already show the new value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA   = 5'h00,
    OFS_DIR    = 5'h04,
    OFS_PAD    = 5'h08,
    OFS_CFG_LO = 5'h0C,
    OFS_CFG_HI = 5'h10,
    OFS_MASK   = 5'h14,
    OFS_STAT   = 5'h18
  } ofs_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   sync_in,
  input  logic [2*NPINS-1:0] cfg,
  input  logic [NPINS-1:0]   clr,
  output logic [NPINS-1:0]   status,
  output logic [NPINS-1:0]   set_v
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] status_q, status_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_e kind;
    logic  lvl, was;
    assign kind = trig_e'(cfg[2*i +: 2]);
    assign lvl  = sync_in[i];
    assign was  = prev_q[i];
    assign set_v[i] = (kind == TRIG_LOW)  ? ~lvl :
                      (kind == TRIG_HIGH) ?  lvl :
                      (kind == TRIG_RISE) ? (lvl & ~was) :
                                            (~lvl & was);
  end

  // A hardware event takes priority over a software clear of the same bit.
  always_comb begin
    status_d = (status_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_in;
      status_q <= status_d;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_out
);
  localparam int unsigned CFG_W = 2 * NPINS;

  logic             rst_int_n;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] data_q, data_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] cfg_lo_q, cfg_lo_d;
  logic [NPINS-1:0] cfg_hi_q, cfg_hi_d;
  logic [NPINS-1:0] rdata_q, rdata_d;
  logic [NPINS-1:0] status_q, set_v, clr_v;
  logic [CFG_W-1:0] cfg_all;
  logic             irq_q, irq_d;
  logic             wr_en, rd_en;
  ofs_e             ofs;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  assign cfg_all = {cfg_hi_q, cfg_lo_q};

  gpio_trig #(.NPINS(NPINS)) u_trig (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sync_in (pin_sync),
    .cfg     (cfg_all),
    .clr     (clr_v),
    .status  (status_q),
    .set_v   (set_v)
  );

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;
  assign ofs   = ofs_e'(bus_addr);
  assign clr_v = (wr_en && ofs == OFS_STAT) ? bus_wdata : '0;

  always_comb begin
    data_d   = data_q;
    dir_d    = dir_q;
    mask_d   = mask_q;
    cfg_lo_d = cfg_lo_q;
    cfg_hi_d = cfg_hi_q;
    if (wr_en) begin
      case (ofs)
        OFS_DATA:   data_d   = bus_wdata;
        OFS_DIR:    dir_d    = bus_wdata;
        OFS_MASK:   mask_d   = bus_wdata;
        OFS_CFG_LO: cfg_lo_d = bus_wdata;
        OFS_CFG_HI: cfg_hi_d = bus_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (ofs)
        OFS_DATA:   rdata_d = data_q;
        OFS_DIR:    rdata_d = dir_q;
        OFS_PAD:    rdata_d = pin_sync;
        OFS_CFG_LO: rdata_d = cfg_lo_q;
        OFS_CFG_HI: rdata_d = cfg_hi_q;
        OFS_MASK:   rdata_d = mask_q;
        OFS_STAT:   rdata_d = status_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_comb begin
    irq_d = |(status_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      data_q   <= data_d;
      dir_q    <= dir_d;
      mask_q   <= mask_d;
      cfg_lo_q <= cfg_lo_d;
      cfg_hi_q <= cfg_hi_d;
      rdata_q  <= rdata_d;
      irq_q    <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = data_q;
  assign pad_oe    = dir_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] set_v,
  input logic [NPINS-1:0] clr_v,
  input logic             irq
);
  // R8: the interrupt line shows last cycle's pending set
  a_r8_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & mask))));

  // R6: a set status bit only drops when software cleared it
  a_r6_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_v)) & ~status) == '0));

  // R7: a cleared bit with no new event reads 0 afterwards
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_v) & ~$past(set_v)) == '0));

  // R9: a detected event always lands in status
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_v) & ~status) == '0));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .status (status_q),
  .mask   (mask_q),
  .set_v  (set_v),
  .clr_v  (clr_v),
  .irq    (irq_out)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [4:0]    bus_addr;
  logic [NP-1:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic          irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  typedef struct {
    logic [NP-1:0] exp;
    string         tag;
  } rd_item_t;
  rd_item_t rd_q[$];
  logic     rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_valid && !bus_write;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) begin
        check(bus_rdata, 'x, "scoreboard-empty");
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic do_write(input logic [4:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, input logic [NP-1:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    rd_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({31'b0, irq_out}, 32'h0, "R1 irq_out");
    check(pad_oe, 32'h0, "R1 pad_oe");
    do_read(5'h04, 32'h0, "R1 direction");
    do_read(5'h14, 32'h0, "R1 mask");
    do_read(5'h0C, 32'h0, "R1 cfg low");
    do_read(5'h10, 32'h0, "R1 cfg high");

    // R2 direction and data
    do_write(5'h00, 32'hA5A5_0F0F);
    do_write(5'h04, 32'h0000_FFFF);
    @(negedge clk);
    check(pad_oe, 32'h0000_FFFF, "R2 pad_oe");
    check(pad_out, 32'hA5A5_0F0F, "R2 pad_out");
    do_read(5'h00, 32'hA5A5_0F0F, "R2 data readback");
    do_write(5'h04, 32'h0);
    @(negedge clk);
    check(pad_oe, 32'h0, "R2 inputs again");

    // R3 synchronized pad level
    pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    do_read(5'h08, 32'h1234_5678, "R3 pad level");
    pad_in = 32'h0;
    do_read(5'h08, 32'h1234_5678, "R3 two-stage latency");
    repeat (2) @(negedge clk);
    do_read(5'h08, 32'h0, "R3 pad settled");
    do_write(5'h08, 32'hFFFF_FFFF);
    do_read(5'h08, 32'h0, "R3 write ignored");

    // quiet setup: all pins high level, pads low
    do_write(5'h0C, 32'h5555_5555);
    do_write(5'h10, 32'h5555_5555);
    do_read(5'h10, 32'h5555_5555, "R4 cfg high readback");
    do_write(5'h18, 32'hFFFF_FFFF);
    do_read(5'h18, 32'h0, "R7 clear all");

    // R6 / R4: pin 3 rising edge (cfg low bits 7:6 = 10)
    do_write(5'h0C, 32'h5555_5595);
    pad_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    pad_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    do_read(5'h18, 32'h0000_0008, "R6 edge latched after idle");

    // R4: pin 20 falling edge (cfg high bits 9:8 = 11)
    do_write(5'h10, 32'h5555_5755);
    pad_in[20] = 1'b1;
    repeat (4) @(negedge clk);
    do_read(5'h18, 32'h0000_0008, "R4 falling ignores rise");
    pad_in[20] = 1'b0;
    repeat (4) @(negedge clk);
    do_read(5'h18, 32'h0010_0008, "R4 pin20 falling in upper cfg");

    // R7 write one to clear
    do_write(5'h18, 32'h0000_0008);
    do_read(5'h18, 32'h0010_0000, "R7 zero bits untouched");
    do_write(5'h18, 32'h0010_0000);
    do_read(5'h18, 32'h0, "R7 second clear");

    // R8 mask
    pad_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    pad_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    check({31'b0, irq_out}, 32'h0, "R8 masked no irq");
    do_read(5'h18, 32'h0000_0008, "R8 status recorded while masked");
    do_write(5'h14, 32'h0000_0008);
    repeat (2) @(negedge clk);
    check({31'b0, irq_out}, 32'h1, "R8 unmasked irq");
    do_write(5'h18, 32'h0000_0008);
    repeat (2) @(negedge clk);
    check({31'b0, irq_out}, 32'h0, "R8 irq drops after clear");
    do_write(5'h14, 32'h0);

    // R5 level high on pin 31
    pad_in[31] = 1'b1;
    repeat (4) @(negedge clk);
    do_read(5'h18, 32'h8000_0000, "R5 high level sets");
    do_write(5'h18, 32'h8000_0000);
    do_read(5'h18, 32'h8000_0000, "R5 level reasserts");
    pad_in[31] = 1'b0;
    repeat (4) @(negedge clk);
    do_write(5'h18, 32'h8000_0000);
    do_read(5'h18, 32'h0, "R5 cleared once idle");

    // R5 level low on pin 0 (cfg low bits 1:0 = 00)
    do_write(5'h0C, 32'h5555_5594);
    repeat (3) @(negedge clk);
    do_read(5'h18, 32'h0000_0001, "R5 low level sets");
    pad_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    do_write(5'h18, 32'h0000_0001);
    do_read(5'h18, 32'h0, "R5 low level cleared");

    // R9 event and clear in the same cycle on pin 3
    @(negedge clk);
    pad_in[3] = 1'b1;
    @(negedge clk);
    do_write(5'h18, 32'h0000_0008);
    pad_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    do_read(5'h18, 32'h0000_0008, "R9 set beats clear");

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule